// File: doc/BRIEF.md
# Burst PWM Bit Encoder

This block drives a single-wire LED data line with a burst of PWM periods. Every period carries one data bit, and the bit is encoded as the length of the high time. A start pulse launches the burst. The block then pulls one compare value per bit from a valid/ready input stream. It emits a fixed number of periods, returns the pin to a low idle level and pulses a completion flag. The period length comes from an up-counter that wraps at a programmable reload value.

Both the compare value and the reload value are double-buffered, so no change lands inside a period that is already running. The stream feeds a one-entry shadow register. The next value may therefore arrive at any point in the current period, and it takes effect at the next update boundary. A repetition setting can space update events N periods apart. With N = 1, every bit can carry its own duty. With a larger N, the burst is built from groups of N periods that share one duty.

Stream rules: an item moves only on a clock edge where `cmp_tvalid` and `cmp_tready` are both high. The source may hold `cmp_tvalid` high for any number of cycles. `cmp_tready` does not depend on `cmp_tvalid`. The block deasserts `cmp_tready` whenever the shadow register is full or no further update remains in the burst, and it never takes a surplus item.

Top module: `pulse_burst_enc`

## Requirements
- R1: After reset, `pwm_out`, `busy`, `done`, `cmp_tready` and `underrun` are all low.
- R2: An accepted start raises `busy` in the next cycle and enters a load phase. In the load phase `cmp_tready` is high until the first item arrives. The handshake on that item works as a forced update: it makes the item the active compare value, captures `reload_val` and `rep_val`, and starts period 0 in the cycle right after the handshake edge.
- R3: A period lasts `reload_val`+1 cycles. `pwm_out` is high exactly while the counter (0 at the start of the period) is below the active compare value. A compare of 0 gives an all-low period, and a compare above the reload value gives an all-high period.
- R4: A burst is exactly BURST_LEN periods. In the cycle after the last period, `done` is high for one cycle, `busy` is low, and `pwm_out` stays low until the next start.
- R5: A compare value taken from the stream becomes active only at the next update boundary. `reload_val` and `rep_val` are sampled only at update boundaries, so changing them mid-period never alters the period in progress.
- R6: With `rep_val` = N−1, an update event occurs at the end of every Nth period, except at the end of the burst. The block accepts exactly 1 + floor((BURST_LEN−1)/N) items per burst. In the run phase, `cmp_tready` is high only while the shadow register is empty and another update event remains. An item handed over in the same cycle as an update event is used directly.
- R7: If no item is present at an update event, `pwm_out` stays low for the following group of periods and `underrun` is set. `underrun` stays set until the next accepted start.
- R8: A start pulse that arrives while `busy` is high has no effect on the burst, on the item count or on the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; honoured only while idle |
| reload_val | input | CNT_W | Counter wrap value (period = value + 1 cycles) |
| rep_val | input | REP_W | Periods per update event minus one |
| cmp_tdata | input | CNT_W | Compare value item |
| cmp_tvalid | input | 1 | Compare item valid |
| cmp_tready | output | 1 | Block can take a compare item |
| pwm_out | output | 1 | Encoded line output, idles low |
| busy | output | 1 | Burst in progress (load or run phase) |
| done | output | 1 | One-cycle pulse after the last period |
| underrun | output | 1 | Sticky flag: an update event found no item |

## Verification
The bench keeps the default widths (16-bit counter, 8-bit repetition field) and the default burst length of 24. Because the counter is 16 bits wide, the bench can use both short periods (reload values 11 and 7) and the full-rate reload of 299 with compare values 95 and 191. The short periods keep bursts brief enough to run the repetition settings of 1, 3 and 5 periods per update, a mid-burst reload change and a deliberately late item. The 8-bit repetition field and the 24-period burst give groups that do not divide the burst evenly (N = 5), so the truncated last group and the exact item count can be observed.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } pbe_state_e;

endpackage

// File: rtl/pbe_period_timer.sv
module pbe_period_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             arr_load,
  input  logic [CNT_W-1:0] reload_in,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] arr_act;

  assign wrap = run && (cnt == arr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      arr_act <= '0;
    end else begin
      if (arr_load) arr_act <= reload_in;
      if (restart) begin
        cnt <= '0;
      end else if (run) begin
        cnt <= wrap ? '0 : cnt + CNT_W'(1);
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= arr_act);

endmodule

// File: rtl/pbe_update_seq.sv
module pbe_update_seq #(
  parameter int BURST_LEN = 24,
  parameter int REP_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             wrap,
  input  logic [REP_W-1:0] rep_in,
  output logic             upd,
  output logic             last,
  output logic             more_upd
);

  localparam int PW = $clog2(BURST_LEN + 1);
  localparam int RW = REP_W + 1;

  logic [PW-1:0] per_left;
  logic [RW-1:0] rep_left;
  logic [RW-1:0] rep_fresh;

  assign rep_fresh = {1'b0, rep_in} + RW'(1);
  assign last      = wrap && (per_left == PW'(1));
  assign upd       = wrap && (rep_left == RW'(1)) && (per_left != PW'(1));
  assign more_upd  = ({{(32-PW){1'b0}}, per_left} > {{(32-RW){1'b0}}, rep_left});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_left <= '0;
      rep_left <= '0;
    end else if (restart) begin
      per_left <= PW'(BURST_LEN);
      rep_left <= rep_fresh;
    end else if (wrap) begin
      per_left <= per_left - PW'(1);
      rep_left <= (rep_left == RW'(1)) ? rep_fresh : rep_left - RW'(1);
    end
  end

  // R4
  no_wrap_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !wrap);

endmodule

// File: rtl/pbe_cmp_buffer.sv
module pbe_cmp_buffer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_mode,
  input  logic             in_run,
  input  logic             upd,
  input  logic             more_upd,
  input  logic [CNT_W-1:0] tdata,
  input  logic             tvalid,
  output logic             tready,
  output logic [CNT_W-1:0] active,
  output logic             hole,
  output logic             underrun
);

  logic [CNT_W-1:0] shadow;
  logic             full;
  logic             fire;

  assign tready = load_mode || (in_run && !full && more_upd);
  assign fire   = tvalid && tready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      full     <= 1'b0;
      active   <= '0;
      hole     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (clear) begin
        underrun <= 1'b0;
        full     <= 1'b0;
      end
      if (load_mode && fire) begin
        active <= tdata;
        hole   <= 1'b0;
        full   <= 1'b0;
      end else if (in_run && upd) begin
        if (full) begin
          active <= shadow;
          hole   <= 1'b0;
          full   <= 1'b0;
        end else if (fire) begin
          active <= tdata;
          hole   <= 1'b0;
        end else begin
          hole     <= 1'b1;
          underrun <= 1'b1;
        end
      end else if (in_run && fire) begin
        shadow <= tdata;
        full   <= 1'b1;
      end
    end
  end

  // R7
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(upd) && !$past(tvalid));

endmodule

// File: rtl/pulse_burst_enc.sv
module pulse_burst_enc #(
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 24,
  parameter int REP_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [REP_W-1:0] rep_val,
  input  logic [CNT_W-1:0] cmp_tdata,
  input  logic             cmp_tvalid,
  output logic             cmp_tready,
  output logic             pwm_out,
  output logic             busy,
  output logic             done,
  output logic             underrun
);

  import pbe_pkg::*;

  pbe_state_e       st;
  logic             start_acc;
  logic             load_fire;
  logic             in_run;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             upd;
  logic             last;
  logic             more_upd;
  logic [CNT_W-1:0] active;
  logic             hole;

  assign in_run    = (st == ST_RUN);
  assign start_acc = start && (st == ST_IDLE);
  assign load_fire = (st == ST_LOAD) && cmp_tvalid;
  assign busy      = (st != ST_IDLE);
  assign pwm_out   = in_run && !hole && (cnt < active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= last;
      unique case (st)
        ST_IDLE: if (start)      st <= ST_LOAD;
        ST_LOAD: if (cmp_tvalid) st <= ST_RUN;
        ST_RUN:  if (last)       st <= ST_IDLE;
        default:                 st <= ST_IDLE;
      endcase
    end
  end

  pbe_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (in_run),
    .restart   (load_fire),
    .arr_load  (load_fire || upd),
    .reload_in (reload_val),
    .cnt       (cnt),
    .wrap      (wrap)
  );

  pbe_update_seq #(.BURST_LEN(BURST_LEN), .REP_W(REP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load_fire),
    .wrap     (wrap),
    .rep_in   (rep_val),
    .upd      (upd),
    .last     (last),
    .more_upd (more_upd)
  );

  pbe_cmp_buffer #(.CNT_W(CNT_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .load_mode (st == ST_LOAD),
    .in_run    (in_run),
    .upd       (upd),
    .more_upd  (more_upd),
    .tdata     (cmp_tdata),
    .tvalid    (cmp_tvalid),
    .tready    (cmp_tready),
    .active    (active),
    .hole      (hole),
    .underrun  (underrun)
  );

  // R3
  rise_at_period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> cnt == '0);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !pwm_out && !cmp_tready);

  // R8
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last |=> busy && !done);

endmodule

// File: tb/test_pulse_burst_enc.sv
module test_pulse_burst_enc;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int BURST_LEN  = 24;
  localparam int REP_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] reload_val = '0;
  logic [REP_W-1:0] rep_val = '0;
  logic [CNT_W-1:0] cmp_tdata = '0;
  logic             cmp_tvalid = 1'b0;
  logic             cmp_tready;
  logic             pwm_out;
  logic             busy;
  logic             done;
  logic             underrun;

  pulse_burst_enc #(.CNT_W(CNT_W), .BURST_LEN(BURST_LEN), .REP_W(REP_W)) i_pulse_burst_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .reload_val (reload_val),
    .rep_val    (rep_val),
    .cmp_tdata  (cmp_tdata),
    .cmp_tvalid (cmp_tvalid),
    .cmp_tready (cmp_tready),
    .pwm_out    (pwm_out),
    .busy       (busy),
    .done       (done),
    .underrun   (underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  int t0 = 0;
  int hs_cnt = 0;

  logic [CNT_W-1:0] fq_data[$];
  int               fq_nb[$];
  int               el_q[$];
  int               eh_q[$];
  string            mon_tag = "R3";
  bit               mon_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // stream driver: presents the queue head once its release cycle is reached
  initial begin
    forever begin
      @(negedge clk);
      if (fq_data.size() > 0 && cyc >= fq_nb[0]) begin
        cmp_tvalid = 1'b1;
        cmp_tdata  = fq_data[0];
      end else begin
        cmp_tvalid = 1'b0;
      end
      if (cmp_tvalid && cmp_tready) begin
        @(posedge clk);
        #1;
        void'(fq_data.pop_front());
        void'(fq_nb.pop_front());
        hs_cnt++;
      end
    end
  end

  // monitor: measures each period and compares with the expected queue
  initial begin
    forever begin
      @(negedge clk);
      if (busy && el_q.size() > 0) begin
        while (!pwm_out) @(negedge clk);
        for (int k = 0; k < BURST_LEN; k++) begin
          int len;
          int hexp;
          int hi;
          len  = el_q.pop_front();
          hexp = eh_q.pop_front();
          hi   = 0;
          for (int j = 0; j < len; j++) begin
            if (!(k == 0 && j == 0)) @(negedge clk);
            if (pwm_out) hi++;
          end
          chk(hi == hexp, mon_tag, $sformatf("period %0d high cycles", k), hi, hexp);
        end
        @(negedge clk);
        chk(done == 1'b1, "R4", "done after last period", int'(done), 1);
        chk(busy == 1'b0, "R4", "busy after last period", int'(busy), 0);
        chk(pwm_out == 1'b0, "R4", "line low after burst", int'(pwm_out), 0);
        chk(cmp_tready == 1'b0, "R6", "ready low after burst", int'(cmp_tready), 0);
        mon_flag = 1'b1;
      end
    end
  end

  task automatic push_item(input int v, input int nb);
    fq_data.push_back(CNT_W'(v));
    fq_nb.push_back(nb);
  endtask

  task automatic push_exp(input int len, input int cmpv);
    el_q.push_back(len);
    eh_q.push_back((cmpv > len) ? len : cmpv);
  endtask

  task automatic begin_burst(input int reload, input int rep, input string tag);
    @(negedge clk);
    reload_val = CNT_W'(reload);
    rep_val    = REP_W'(rep);
    mon_tag    = tag;
    mon_flag   = 1'b0;
    hs_cnt     = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(pwm_out == 1'b0, "R2", "line low in load phase", int'(pwm_out), 0);
    chk(cmp_tready == 1'b1, "R2", "ready in load phase", int'(cmp_tready), 1);
    chk(underrun == 1'b0, "R7", "underrun cleared by start", int'(underrun), 0);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R2", "period 0 begins after first handshake", int'(pwm_out), 1);
  endtask

  task automatic end_burst();
    wait (mon_flag == 1'b1);
    @(negedge clk);
    fq_data.delete();
    fq_nb.delete();
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog: actual=hung expected=burst end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int d[24];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1", "reset pwm_out", int'(pwm_out), 0);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(cmp_tready == 1'b0, "R1", "reset ready", int'(cmp_tready), 0);
    chk(underrun == 1'b0, "R1", "reset underrun", int'(underrun), 0);

    // per-bit modulation, compare corners, start ignored mid-burst (R3, R8)
    for (int i = 0; i < 24; i++) begin
      d[i] = (i % 3 == 0) ? 8 : 4;
      if (i == 5) d[i] = 0;
      if (i == 6) d[i] = 15;
      if (i == 7) d[i] = 12;
      push_item(d[i], 0);
      push_exp(12, d[i]);
    end
    begin_burst(11, 0, "R3");
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "start ignored while busy", int'(busy), 1);
    end_burst();
    chk(hs_cnt == 24, "R8", "items per burst with extra start", hs_cnt, 24);

    // reload change in mid-period takes effect at the next boundary (R5)
    for (int i = 0; i < 24; i++) begin
      d[i] = (i % 2 == 0) ? 3 : 6;
      push_item(d[i], 0);
      push_exp((i <= 3) ? 12 : 8, d[i]);
    end
    begin_burst(11, 0, "R5");
    while (cyc < t0 + 1 + 3 * 12 + 6) @(negedge clk);
    reload_val = CNT_W'(7);
    end_burst();
    chk(hs_cnt == 24, "R5", "items with reload change", hs_cnt, 24);

    // repetition: update every 3 periods (R6)
    for (int i = 0; i < 10; i++) push_item(2 + i, 0);
    for (int k = 0; k < 24; k++) push_exp(12, 2 + k / 3);
    begin_burst(11, 2, "R6");
    end_burst();
    chk(hs_cnt == 8, "R6", "items taken with N=3", hs_cnt, 8);

    // repetition: update every 5 periods, short last group (R6)
    for (int i = 0; i < 7; i++) push_item(3 + 2 * i, 0);
    for (int k = 0; k < 24; k++) push_exp(12, 3 + 2 * (k / 5));
    begin_burst(11, 4, "R6");
    end_burst();
    chk(hs_cnt == 5, "R6", "items taken with N=5", hs_cnt, 5);

    // underrun: the third item arrives after its boundary (R7)
    push_item(5, 0);
    push_item(9, 0);
    push_exp(12, 5);
    push_exp(12, 9);
    push_exp(12, 0);
    for (int k = 3; k < 24; k++) push_exp(12, ((k - 1) % 2 == 1) ? 9 : 5);
    begin_burst(11, 0, "R7");
    for (int j = 2; j < 23; j++) push_item((j % 2 == 1) ? 9 : 5, t0 + 1 + 2 * 12 + 6);
    end_burst();
    chk(underrun == 1'b1, "R7", "underrun flag set", int'(underrun), 1);
    chk(hs_cnt == 23, "R7", "items taken with one hole", hs_cnt, 23);

    // full-rate burst, 300-cycle period, 95/191 compare (R3)
    for (int i = 0; i < 24; i++) begin
      d[i] = ((24'hA5C3F0 >> (23 - i)) & 1) != 0 ? 191 : 95;
      push_item(d[i], 0);
      push_exp(300, d[i]);
    end
    begin_burst(299, 0, "R3");
    end_burst();
    chk(hs_cnt == 24, "R6", "items at full rate", hs_cnt, 24);
    chk(underrun == 1'b0, "R7", "no underrun at full rate", int'(underrun), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule